// File: doc/BRIEF.md
# Debug Register Target

This block is the register endpoint that a debug host uses to control a processor core and inspect it. The host reaches it over a small request/acknowledge bus. Each transaction carries a 4-bit register address, a write flag and 64-bit write data, and the target answers once with a single-cycle acknowledge and 64-bit read data. Writes to the control register halt the core or let a halted core advance by exactly one instruction. Reads return the core's run state, its next-instruction address, its machine state word, its condition register and its fixed-point exception flags, packed into a word.

General registers are reached indirectly. The host writes a register number into an index register, and the target drives that number to the core's register file. A read of the data address then returns the selected register's value. The core side has a level `core_stop` and a one-cycle `core_step` pulse. The core reports back whether it has come to rest, and it supplies its architectural state as plain inputs.

Top module: `dbg_target`

## Requirements
- R1: A rising request is acknowledged exactly one clock later with `dbg_ack` high for one cycle. Read data is valid in that acknowledge cycle, and `dbg_rdata` is zero in every other cycle, including write acknowledges.
- R2: If the request stays high after its acknowledge, no second acknowledge is produced. A new transaction needs the request to drop for at least one cycle first.
- R3: A write to address 0 with bit 0 set raises `core_stop` in the acknowledge cycle. It then stays high until reset, so a further halt write changes nothing.
- R4: A write to address 0 with bit 3 set gives a one-cycle `core_step` pulse in the acknowledge cycle, but only when `core_stopped` is high at acceptance. While the core runs, the write is ignored.
- R5: A read of address 1 returns `core_stopped` in bit 1, and every other bit reads 0.
- R6: Reads of address 2, 3 and 8 return `core_nia`, `core_msr` and `core_cr` respectively.
- R7: A write to address 4 loads the low 5 bits of the write data into the general register index, which is driven on `core_gpr_sel` from the next cycle. Reading address 4 returns the index, zero-extended. Reading address 5 returns `core_gpr_val`.
- R8: A read of address 9 packs `core_xer_flags` (bit0 summary overflow, bit1 carry, bit2 32-bit carry, bit3 overflow, bit4 32-bit overflow) into result bits 0, 2, 3, 4 and 5 in that order. All other bits are 0.
- R9: Addresses 6, 7 and 10 to 15 read as zero, and address 0 also reads as zero. Writes to unassigned addresses change no state. All of these are acknowledged normally.
- R10: After reset, `dbg_ack`, `dbg_rdata`, `core_stop`, `core_step` and `core_gpr_sel` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dbg_req | input | 1 | Transaction request, held until acknowledged |
| dbg_we | input | 1 | 1 for write, 0 for read |
| dbg_addr | input | 4 | Register address |
| dbg_wdata | input | 64 | Write data |
| dbg_ack | output | 1 | One-cycle acknowledge |
| dbg_rdata | output | 64 | Read data, valid with the acknowledge |
| core_stop | output | 1 | Halt request level to the core |
| core_step | output | 1 | One-instruction advance pulse |
| core_stopped | input | 1 | Core reports it is at rest |
| core_nia | input | 64 | Next-instruction address |
| core_msr | input | 64 | Machine state word |
| core_cr | input | 64 | Condition register |
| core_xer_flags | input | 5 | Exception flags: so, ca, ca32, ov, ov32 (bit 0 upward) |
| core_gpr_sel | output | 5 | Selected general register number |
| core_gpr_val | input | 64 | Value of the selected general register |

## Verification
The assertions check the following on every cycle: a single acknowledge per request edge, `core_stop` staying high once set, step pulses only while stopped and never longer than one cycle, the exception word's reserved bits, and zero data from unassigned addresses. Some behaviours show only in the bench's scenarios, which run against a stub core that advances its instruction address by 4 per step. These are: a step written while the core runs has no effect on the instruction address; halt, status and step sequences produce the expected visible addresses; the indirect register path returns the value of the register that was written in; and writes to unassigned addresses leave the index and run state untouched.

// File: rtl/dbg_target_pkg.sv
package dbg_target_pkg;

  localparam int ADDR_W    = 4;
  localparam int XER_NFLAG = 5;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 4'd0,
    RA_STAT = 4'd1,
    RA_NIA  = 4'd2,
    RA_MSR  = 4'd3,
    RA_GIDX = 4'd4,
    RA_GDAT = 4'd5,
    RA_CR   = 4'd8,
    RA_XER  = 4'd9
  } reg_addr_e;

  localparam int CTRL_HALT_BIT = 0;
  localparam int CTRL_STEP_BIT = 3;
  localparam int STAT_STOP_BIT = 1;

  // flag input order: so, ca, ca32, ov, ov32 -> result bit positions
  localparam int XER_POS [XER_NFLAG] = '{0, 2, 3, 4, 5};

  function automatic logic addr_known(input logic [ADDR_W-1:0] a);
    case (a)
      RA_CTRL, RA_STAT, RA_NIA, RA_MSR,
      RA_GIDX, RA_GDAT, RA_CR, RA_XER: addr_known = 1'b1;
      default:                         addr_known = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dbg_hs.sv
module dbg_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic accept,
  output logic ack
);

  logic req_seen_q, req_seen_d;
  logic ack_q, ack_d;

  always_comb begin
    accept     = req & ~req_seen_q;
    req_seen_d = req;
    ack_d      = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen_q <= 1'b0;
      ack_q      <= 1'b0;
    end else begin
      req_seen_q <= req_seen_d;
      ack_q      <= ack_d;
    end
  end

  assign ack = ack_q;

  a_r1_ack_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> $past(req));

  a_r2_no_double_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> !ack);

endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic halt_bit,
  input  logic step_bit,
  input  logic core_stopped,
  output logic core_stop,
  output logic core_step
);

  logic stop_q, stop_d, stop_en;
  logic step_q, step_d;

  always_comb begin
    stop_en = wr_ctrl & halt_bit;
    stop_d  = 1'b1;
    step_d  = wr_ctrl & step_bit & core_stopped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      step_q <= 1'b0;
    end else begin
      if (stop_en) stop_q <= stop_d;
      step_q <= step_d;
    end
  end

  assign core_stop = stop_q;
  assign core_step = step_q;

  a_r3_stop_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    core_stop |=> core_stop);

  a_r4_step_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |-> $past(core_stopped));

  a_r4_step_single: assert property (@(posedge clk) disable iff (!rst_n)
    core_step |=> !core_step);

endmodule

// File: rtl/dbg_regfile.sv
module dbg_regfile
  import dbg_target_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int NGPR   = 32,
  localparam int IDX_W  = $clog2(NGPR)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  wdata_idx,
  input  logic              core_stopped,
  input  logic [DATA_W-1:0] core_nia,
  input  logic [DATA_W-1:0] core_msr,
  input  logic [DATA_W-1:0] core_cr,
  input  logic [XER_NFLAG-1:0] core_xer_flags,
  input  logic [DATA_W-1:0] core_gpr_val,
  input  logic              ack,
  output logic [IDX_W-1:0]  gpr_sel,
  output logic [DATA_W-1:0] rdata
);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] xer_word, stat_word, rd_mux;

  always_comb begin
    xer_word = '0;
    for (int i = 0; i < XER_NFLAG; i++) begin
      xer_word[XER_POS[i]] = core_xer_flags[i];
    end
    stat_word = '0;
    stat_word[STAT_STOP_BIT] = core_stopped;
  end

  always_comb begin
    case (addr)
      RA_STAT: rd_mux = stat_word;
      RA_NIA:  rd_mux = core_nia;
      RA_MSR:  rd_mux = core_msr;
      RA_GIDX: rd_mux = DATA_W'(idx_q);
      RA_GDAT: rd_mux = core_gpr_val;
      RA_CR:   rd_mux = core_cr;
      RA_XER:  rd_mux = xer_word;
      default: rd_mux = '0;
    endcase
  end

  always_comb begin
    idx_en  = accept & we & (addr == RA_GIDX);
    idx_d   = wdata_idx;
    rdata_d = (accept & ~we) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (idx_en) idx_q <= idx_d;
      rdata_q <= rdata_d;
    end
  end

  assign gpr_sel = idx_q;
  assign rdata   = rdata_q;

  a_r7_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && we && addr == RA_GIDX) |=> gpr_sel == $past(wdata_idx));

  a_r8_xer_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(!we && addr == RA_XER)) |->
      (rdata[DATA_W-1:6] == '0 && rdata[1] == 1'b0));

  a_r9_unassigned_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(!we && !addr_known(addr))) |-> rdata == '0);

  a_r9_unassigned_write: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && we && !addr_known(addr)) |=> $stable(gpr_sel));

  a_r5_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(!we && addr == RA_STAT)) |->
      (rdata[STAT_STOP_BIT] == $past(core_stopped) && $countones(rdata) <= 1));

endmodule

// File: rtl/dbg_target.sv
module dbg_target
  import dbg_target_pkg::*;
#(
  parameter  int DATA_W = 64,
  parameter  int NGPR   = 32,
  localparam int IDX_W  = $clog2(NGPR)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbg_req,
  input  logic                 dbg_we,
  input  logic [ADDR_W-1:0]    dbg_addr,
  input  logic [DATA_W-1:0]    dbg_wdata,
  output logic                 dbg_ack,
  output logic [DATA_W-1:0]    dbg_rdata,
  output logic                 core_stop,
  output logic                 core_step,
  input  logic                 core_stopped,
  input  logic [DATA_W-1:0]    core_nia,
  input  logic [DATA_W-1:0]    core_msr,
  input  logic [DATA_W-1:0]    core_cr,
  input  logic [XER_NFLAG-1:0] core_xer_flags,
  output logic [IDX_W-1:0]     core_gpr_sel,
  input  logic [DATA_W-1:0]    core_gpr_val
);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;
  logic       accept;
  logic       wr_ctrl;
  logic       unused_wdata_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  assign wr_ctrl         = accept & dbg_we & (dbg_addr == RA_CTRL);
  assign unused_wdata_hi = ^dbg_wdata[DATA_W-1:IDX_W];

  dbg_hs u_hs (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .req    (dbg_req),
    .accept (accept),
    .ack    (dbg_ack)
  );

  dbg_runctl u_runctl (
    .clk          (clk),
    .rst_n        (rst_s_n),
    .wr_ctrl      (wr_ctrl),
    .halt_bit     (dbg_wdata[CTRL_HALT_BIT]),
    .step_bit     (dbg_wdata[CTRL_STEP_BIT]),
    .core_stopped (core_stopped),
    .core_stop    (core_stop),
    .core_step    (core_step)
  );

  dbg_regfile #(.DATA_W(DATA_W), .NGPR(NGPR)) u_regs (
    .clk            (clk),
    .rst_n          (rst_s_n),
    .accept         (accept),
    .we             (dbg_we),
    .addr           (dbg_addr),
    .wdata_idx      (dbg_wdata[IDX_W-1:0]),
    .core_stopped   (core_stopped),
    .core_nia       (core_nia),
    .core_msr       (core_msr),
    .core_cr        (core_cr),
    .core_xer_flags (core_xer_flags),
    .core_gpr_val   (core_gpr_val),
    .ack            (dbg_ack),
    .gpr_sel        (core_gpr_sel),
    .rdata          (dbg_rdata)
  );

  a_r10_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(rst_s_n) |-> (!dbg_ack && !core_step && !core_stop && core_gpr_sel == '0));

endmodule

// File: tb/test_dbg_target.sv
`timescale 1ns/1ps
module test_dbg_target;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dbg_req, dbg_we;
  logic [3:0]  dbg_addr;
  logic [63:0] dbg_wdata;
  logic        dbg_ack;
  logic [63:0] dbg_rdata;
  logic        core_stop, core_step;
  logic        stub_stopped;
  logic [63:0] stub_nia;
  logic [63:0] stub_msr = 64'h8000_0000_0000_1033;
  logic [63:0] stub_cr  = 64'h0000_0000_4822_0084;
  logic [4:0]  xer_flags;
  logic [4:0]  gpr_sel;
  logic [63:0] gpr_val;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dbg_target i_dbg_target (
    .clk(clk), .rst_n(rst_n), .dbg_req(dbg_req), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_ack(dbg_ack),
    .dbg_rdata(dbg_rdata), .core_stop(core_stop), .core_step(core_step),
    .core_stopped(stub_stopped), .core_nia(stub_nia), .core_msr(stub_msr),
    .core_cr(stub_cr), .core_xer_flags(xer_flags), .core_gpr_sel(gpr_sel),
    .core_gpr_val(gpr_val)
  );

  // stub core: follows the stop level, advances by 4 on each step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stub_stopped <= 1'b0;
      stub_nia     <= 64'h1000;
    end else begin
      stub_stopped <= core_stop;
      if (core_step && stub_stopped) stub_nia <= stub_nia + 64'd4;
    end
  end

  function automatic logic [63:0] gpr_model(input logic [4:0] i);
    return 64'hA5A5_0000_0000_0000 | (64'(i) * 64'h111);
  endfunction
  assign gpr_val = gpr_model(gpr_sel);

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: every acknowledge pops one expected data word
  always @(negedge clk) begin
    if (rst_n && dbg_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected acknowledge", 64'd1, 64'd0);
      end else begin
        logic [63:0] e;
        string       t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(dbg_rdata === e, t, dbg_rdata, e);
      end
    end
  end

  task automatic xact(input logic [3:0] a, input logic w, input logic [63:0] d,
                      input logic [63:0] exp, input string tag, input int hold,
                      output logic stop_at_ack, output logic step_at_ack);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    dbg_addr  = a;
    dbg_we    = w;
    dbg_wdata = d;
    dbg_req   = 1'b1;
    @(negedge clk);
    check(dbg_ack === 1'b1, "R1 acknowledge one cycle after request", 64'(dbg_ack), 64'd1);
    stop_at_ack = core_stop;
    step_at_ack = core_step;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(dbg_ack === 1'b0, "R2 held request acknowledged again", 64'(dbg_ack), 64'd0);
    end
    dbg_req = 1'b0;
    @(negedge clk);
    check(dbg_ack === 1'b0 && dbg_rdata === 64'd0, "R1 idle data not zero", dbg_rdata, 64'd0);
  endtask

  task automatic rd(input logic [3:0] a, input logic [63:0] exp, input string tag);
    logic s0, s1;
    xact(a, 1'b0, 64'd0, exp, tag, 0, s0, s1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d, input string tag,
                    input int hold, output logic stop_at_ack, output logic step_at_ack);
    xact(a, 1'b1, d, 64'd0, tag, hold, stop_at_ack, step_at_ack);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic sa, st;
    rst_n = 1'b0; dbg_req = 1'b0; dbg_we = 1'b0; dbg_addr = '0; dbg_wdata = '0;
    xer_flags = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(dbg_ack === 1'b0 && dbg_rdata === 64'd0, "R10 bus idle in reset", dbg_rdata, 64'd0);
    check(core_stop === 1'b0 && core_step === 1'b0, "R10 run controls low",
          64'({core_stop, core_step}), 64'd0);
    check(gpr_sel === 5'd0, "R10 index clear (R7)", 64'(gpr_sel), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(core_stop === 1'b0 && gpr_sel === 5'd0, "R10 state after release",
          64'({core_stop, gpr_sel}), 64'd0);

    // running core
    rd(4'd1, 64'd0, "R5 status while running");
    rd(4'd2, 64'h1000, "R6 next-instruction address");
    wr(4'd0, 64'h8, "R4 step write ack data", 0, sa, st);
    check(st === 1'b0, "R4 step ignored while running", 64'(st), 64'd0);
    rd(4'd2, 64'h1000, "R4 address unchanged after ignored step");

    // halt with request held for three extra cycles
    wr(4'd0, 64'h1, "R3 halt write ack data", 3, sa, st);
    check(sa === 1'b1, "R3 stop raised in ack cycle", 64'(sa), 64'd1);
    rd(4'd1, 64'h2, "R5 status while stopped");

    // single steps
    wr(4'd0, 64'h8, "R4 step write ack data", 0, sa, st);
    check(st === 1'b1, "R4 step pulse in ack cycle", 64'(st), 64'd1);
    check(core_step === 1'b0, "R4 step pulse one cycle", 64'(core_step), 64'd0);
    rd(4'd2, 64'h1004, "R4 address after one step");
    wr(4'd0, 64'h9, "R4 halt+step write ack data", 0, sa, st);
    check(st === 1'b1 && sa === 1'b1, "R4 combined halt and step",
          64'({sa, st}), 64'd3);
    rd(4'd2, 64'h1008, "R4 address after second step");

    // halt while already stopped
    wr(4'd0, 64'h1, "R3 repeat halt ack data", 0, sa, st);
    check(core_stop === 1'b1 && st === 1'b0, "R3 repeat halt no effect",
          64'({core_stop, st}), 64'd2);
    rd(4'd2, 64'h1008, "R3 address unchanged by repeat halt");
    rd(4'd1, 64'h2, "R5 status still stopped");

    rd(4'd3, 64'h8000_0000_0000_1033, "R6 machine state");
    rd(4'd8, 64'h0000_0000_4822_0084, "R6 condition register");

    // indirect general registers
    wr(4'd4, 64'd7, "R7 index write ack data", 0, sa, st);
    check(gpr_sel === 5'd7, "R7 select drives index", 64'(gpr_sel), 64'd7);
    rd(4'd5, gpr_model(5'd7), "R7 register 7 data");
    wr(4'd4, 64'hFFFF_FFFF_FFFF_FFFF, "R7 index write ack data", 0, sa, st);
    rd(4'd4, 64'd31, "R7 index readback truncated to 5 bits");
    rd(4'd5, gpr_model(5'd31), "R7 register 31 data");
    wr(4'd4, 64'd0, "R7 index write ack data", 0, sa, st);
    rd(4'd5, gpr_model(5'd0), "R7 register 0 data");
    wr(4'd4, 64'd19, "R7 index write ack data", 0, sa, st);

    // exception flags packing
    xer_flags = 5'b10101;
    rd(4'd9, 64'h29, "R8 so ca32 ov32");
    xer_flags = 5'b01010;
    rd(4'd9, 64'h14, "R8 ca ov");
    xer_flags = 5'b11111;
    rd(4'd9, 64'h3D, "R8 all flags");

    // unassigned addresses
    wr(4'd6, 64'hDEAD_BEEF_0000_0004, "R9 unassigned write ack", 0, sa, st);
    wr(4'd15, 64'h1, "R9 unassigned write ack", 0, sa, st);
    rd(4'd6, 64'd0, "R9 address 6 reads zero");
    rd(4'd15, 64'd0, "R9 address 15 reads zero");
    rd(4'd0, 64'd0, "R9 control reads zero");
    rd(4'd4, 64'd19, "R9 index untouched by unassigned writes");
    check(core_stop === 1'b1 && stub_nia === 64'h1008, "R9 run state untouched",
          stub_nia, 64'h1008);

    check(exp_q.size() == 0, "R1 every transaction acknowledged", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule